// File: doc/BRIEF.md
# Row-Limited Byte Write Sequencer

This block sits behind the serial bus engine of a small 256 x 8 non-volatile store. For each write transaction it is told the starting byte address. It then receives the data bytes one at a time and holds them in a row-sized staging buffer. When the transaction closes, it copies them into the storage array during a self-timed program cycle. The program cycle is counted in system-clock ticks, and `busy` stays high for all of it. While `busy` is high, every bus-side request is dropped.

A row is eight consecutive bytes. In page mode the address advances only within the row, so a long burst wraps and overwrites its own earlier bytes. In multibyte mode up to four bytes go to consecutive addresses anywhere in the array. If they cross into a second row, the program cycle lasts twice as long. A build-time option selects the protected variant. That variant has a write-protect input that can discard a whole transaction, and it always uses page mode.

Top module: `wbuf_seq`

## Requirements
- R1: After reset, `busy` is low and every array location reads 8'hFF.
- R2: With page mode latched (`mode_multi`=0), data byte k of a transaction starting at address A lands at {A[7:3], (A[2:0]+k) mod 8}. A later byte to the same location replaces the earlier one, and every byte of the burst is accepted.
- R3: With multibyte mode latched (`mode_multi`=1, open variant), byte k for k<4 lands at (A+k) mod 256, and the fifth and later bytes are ignored.
- R4: A program cycle keeps `busy` high for exactly PROG_TICKS cycles. It lasts 2*PROG_TICKS cycles when a multibyte write places bytes in two rows (row = address bits 7..3).
- R5: A program cycle starts only on `txn_stop` of a transaction that delivered at least one data byte. A transaction with no data bytes leaves `busy` low and the array unchanged.
- R6: `busy` rises in the cycle after `txn_stop` is sampled. The array keeps its old contents while `busy` is high, and all staged bytes appear together when `busy` falls.
- R7: While `busy` is high, `txn_start`, `data_valid` and `txn_stop` have no effect.
- R8: In the protected variant, `wr_protect`=1 sampled with `txn_stop` discards the write: the array is unchanged and `busy` stays low. That variant uses page mode whatever `mode_multi` is.
- R9: The open variant ignores `wr_protect`.
- R10: The write mode is taken from `mode_multi` in the `txn_start` cycle. Later changes during the transaction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Opens a write transaction at `txn_addr` |
| txn_addr | input | 8 | Starting byte address |
| data_valid | input | 1 | One data byte received on the bus |
| data_byte | input | 8 | Received data byte |
| txn_stop | input | 1 | Bus stop ending the transaction |
| mode_multi | input | 1 | 1 selects multibyte mode, 0 page mode |
| wr_protect | input | 1 | Discards the write in the protected variant |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 8 | Array contents at `rd_addr` |
| busy | output | 1 | Program cycle in progress |

## Verification
The assertions check, on every cycle, the behaviour that can be seen locally. `busy` cannot drop while its tick counter is still running. It can rise only right after a stop. The array cannot change outside the commit cycle. The staging buffer holds still while busy and never holds more than four multibyte entries. Only the bench's sweeps show the rest. These cover the placement of bytes in each mode, the exact program length including the doubled row-crossing case and the 8'hFF-to-8'h00 wrap, the effect of write protection, the latching of the mode, and whether traffic injected during busy is really lost.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic {
        WM_PAGE  = 1'b0,
        WM_MULTI = 1'b1
    } wr_mode_e;

    typedef enum logic {
        COL_IDLE   = 1'b0,
        COL_ACTIVE = 1'b1
    } col_state_e;
endpackage

// File: rtl/wbuf_collect.sv
module wbuf_collect
    import wbuf_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int ROW_BITS  = 3,
    parameter int MULTI_MAX = 4,
    parameter bit PROTECTED = 1'b0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              busy_i,
    input  logic                              txn_start_i,
    input  logic [ADDR_W-1:0]                 txn_addr_i,
    input  logic                              data_valid_i,
    input  logic [DATA_W-1:0]                 data_byte_i,
    input  logic                              txn_stop_i,
    input  logic                              mode_multi_i,
    input  logic                              wr_protect_i,
    output logic                              launch_o,
    output logic                              long_o,
    output logic [(1<<ROW_BITS)-1:0]          slot_vld_o,
    output logic [(1<<ROW_BITS)-1:0][ADDR_W-1:0] slot_addr_o,
    output logic [(1<<ROW_BITS)-1:0][DATA_W-1:0] slot_data_o
);
    localparam int ROWLEN = 1 << ROW_BITS;
    localparam int ROW_W  = ADDR_W - ROW_BITS;
    localparam int CNT_W  = $clog2(MULTI_MAX + 1);

    typedef struct packed {
        col_state_e                        st;
        wr_mode_e                          mode;
        logic [ADDR_W-1:0]                 cur;
        logic [ROW_W-1:0]                  row;
        logic [CNT_W-1:0]                  cnt;
        logic                              span;
        logic [ROWLEN-1:0]                 vld;
        logic [ROWLEN-1:0][ADDR_W-1:0]     addr;
        logic [ROWLEN-1:0][DATA_W-1:0]     data;
    } col_t;

    col_t s_d, s_q;
    logic mode_sel;
    logic wp_block;
    logic launch_d;
    logic [ROW_BITS-1:0] slot;

    if (PROTECTED) begin : g_prot
        wire unused_mode = mode_multi_i;
        assign mode_sel = 1'b0;
        assign wp_block = wr_protect_i;
    end else begin : g_open
        wire unused_wp = wr_protect_i;
        assign mode_sel = mode_multi_i;
        assign wp_block = 1'b0;
    end

    always_comb begin
        s_d      = s_q;
        launch_d = 1'b0;
        slot     = '0;
        if (!busy_i) begin
            if (txn_start_i) begin
                s_d.st   = COL_ACTIVE;
                s_d.mode = mode_sel ? WM_MULTI : WM_PAGE;
                s_d.cur  = txn_addr_i;
                s_d.row  = txn_addr_i[ADDR_W-1:ROW_BITS];
                s_d.cnt  = '0;
                s_d.span = 1'b0;
                s_d.vld  = '0;
            end else if (s_q.st == COL_ACTIVE) begin
                if (txn_stop_i) begin
                    s_d.st   = COL_IDLE;
                    launch_d = (|s_q.vld) && !wp_block;
                end else if (data_valid_i) begin
                    if (s_q.mode == WM_PAGE) begin
                        slot = s_q.cur[ROW_BITS-1:0];
                        s_d.vld[slot]  = 1'b1;
                        s_d.addr[slot] = s_q.cur;
                        s_d.data[slot] = data_byte_i;
                        s_d.cur = {s_q.cur[ADDR_W-1:ROW_BITS],
                                   s_q.cur[ROW_BITS-1:0] + 1'b1};
                    end else if (s_q.cnt < CNT_W'(MULTI_MAX)) begin
                        slot = ROW_BITS'(s_q.cnt);
                        s_d.vld[slot]  = 1'b1;
                        s_d.addr[slot] = s_q.cur;
                        s_d.data[slot] = data_byte_i;
                        s_d.cur = s_q.cur + 1'b1;
                        s_d.cnt = s_q.cnt + 1'b1;
                        if (s_q.cur[ADDR_W-1:ROW_BITS] != s_q.row) begin
                            s_d.span = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign launch_o    = launch_d;
    assign long_o      = s_q.span && (s_q.mode == WM_MULTI);
    assign slot_vld_o  = s_q.vld;
    assign slot_addr_o = s_q.addr;
    assign slot_data_o = s_q.data;

    AST_MB_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == WM_MULTI) |-> ($countones(s_q.vld) <= MULTI_MAX)); // R3
    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(s_q.vld) && $stable(s_q.data)); // R7
endmodule

// File: rtl/wbuf_timer.sv
module wbuf_timer #(
    parameter int PROG_TICKS = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic long_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(2 * PROG_TICKS + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end else if (launch_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = long_i ? CNT_W'(2 * PROG_TICKS - 1) : CNT_W'(PROG_TICKS - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy_o = t_q.busy;
    assign done_o = t_q.busy && (t_q.cnt == '0);

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.busy && t_q.cnt != '0) |=> t_q.busy); // R4
    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.busy |-> !launch_i); // R7
endmodule

// File: rtl/wbuf_array.sv
module wbuf_array #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int ROW_BITS = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 commit_i,
    input  logic [(1<<ROW_BITS)-1:0]             slot_vld_i,
    input  logic [(1<<ROW_BITS)-1:0][ADDR_W-1:0] slot_addr_i,
    input  logic [(1<<ROW_BITS)-1:0][DATA_W-1:0] slot_data_i,
    input  logic [ADDR_W-1:0]                    rd_addr_i,
    output logic [DATA_W-1:0]                    rd_data_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int ROWLEN = 1 << ROW_BITS;

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (commit_i) begin
            for (int i = 0; i < ROWLEN; i++) begin
                if (slot_vld_i[i]) begin
                    mem_d[slot_addr_i[i]] = slot_data_i[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    AST_HOLD_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(mem_q)); // R6
endmodule

// File: rtl/wbuf_seq.sv
module wbuf_seq #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int ROW_BITS   = 3,
    parameter int MULTI_MAX  = 4,
    parameter int PROG_TICKS = 2_000_000,
    parameter bit PROTECTED  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_byte,
    input  logic              txn_stop,
    input  logic              mode_multi,
    input  logic              wr_protect,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int ROWLEN = 1 << ROW_BITS;

    logic                          launch;
    logic                          long_cycle;
    logic                          done;
    logic [ROWLEN-1:0]             slot_vld;
    logic [ROWLEN-1:0][ADDR_W-1:0] slot_addr;
    logic [ROWLEN-1:0][DATA_W-1:0] slot_data;

    wbuf_collect #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BITS(ROW_BITS),
        .MULTI_MAX(MULTI_MAX), .PROTECTED(PROTECTED)
    ) u_collect (
        .clk(clk), .rst_n(rst_n), .busy_i(busy),
        .txn_start_i(txn_start), .txn_addr_i(txn_addr),
        .data_valid_i(data_valid), .data_byte_i(data_byte),
        .txn_stop_i(txn_stop), .mode_multi_i(mode_multi),
        .wr_protect_i(wr_protect), .launch_o(launch), .long_o(long_cycle),
        .slot_vld_o(slot_vld), .slot_addr_o(slot_addr), .slot_data_o(slot_data)
    );

    wbuf_timer #(.PROG_TICKS(PROG_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .long_i(long_cycle),
        .busy_o(busy), .done_o(done)
    );

    wbuf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BITS(ROW_BITS)) u_array (
        .clk(clk), .rst_n(rst_n), .commit_i(done),
        .slot_vld_i(slot_vld), .slot_addr_i(slot_addr), .slot_data_i(slot_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(txn_stop)); // R5
endmodule

// File: tb/wbuf_seq_bench.sv
`timescale 1ns/1ps
module wbuf_seq_bench;
    localparam int T = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0, data_valid = 1'b0, txn_stop = 1'b0;
    logic       mode_multi = 1'b0, wr_protect = 1'b0;
    logic [7:0] txn_addr = '0, data_byte = '0, rd_addr = '0;
    logic [7:0] rd0, rd1;
    logic       busy0, busy1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int seq = 0;
    logic [7:0] exp0 [256];
    logic [7:0] exp1 [256];

    always #2.5 clk = ~clk;

    wbuf_seq #(.PROG_TICKS(T), .PROTECTED(1'b0)) u_wbuf_seq (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
        .data_valid(data_valid), .data_byte(data_byte), .txn_stop(txn_stop),
        .mode_multi(mode_multi), .wr_protect(wr_protect), .rd_addr(rd_addr),
        .rd_data(rd0), .busy(busy0));

    wbuf_seq #(.PROG_TICKS(T), .PROTECTED(1'b1)) u_wbuf_seq_wp (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
        .data_valid(data_valid), .data_byte(data_byte), .txn_stop(txn_stop),
        .mode_multi(mode_multi), .wr_protect(wr_protect), .rd_addr(rd_addr),
        .rd_data(rd1), .busy(busy1));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sweep(input string tag0, input string tag1);
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a);
            #0.5;
            chk(rd0 == exp0[a], tag0, rd0, exp0[a]);
            chk(rd1 == exp1[a], tag1, rd1, exp1[a]);
        end
    endtask

    task automatic run_txn(input int a, input int n, input bit m, input bit wc,
                           input bit inj);
        logic [7:0] d [10];
        int e0, e1, c0, c1, k, nb, last;
        bit span;
        seq++;
        for (int i = 0; i < 10; i++) d[i] = 8'(a * 3 + i * 29 + seq * 11 + 1);
        @(negedge clk);
        txn_start = 1'b1; txn_addr = 8'(a); mode_multi = m; wr_protect = wc;
        @(negedge clk);
        txn_start = 1'b0;
        mode_multi = ~m;            // R10: late change must not matter
        for (int i = 0; i < n; i++) begin
            data_valid = 1'b1; data_byte = d[i];
            @(negedge clk);
        end
        data_valid = 1'b0; txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
        nb   = (n < 4) ? n : 4;
        last = (a + nb - 1) & 255;
        span = ((last >> 3) != (a >> 3));
        e0 = (n == 0) ? 0 : ((m && span) ? 2 * T : T);
        e1 = (n == 0 || wc) ? 0 : T;
        if (e0 > 0) begin
            rd_addr = 8'(a);
            #0.5;
            chk(rd0 == exp0[a], "R6 array held during busy", rd0, exp0[a]);
            chk(busy0 == 1'b1, "R6 busy rises after stop", busy0, 1);
        end
        c0 = 0; c1 = 0; k = 0;
        while ((busy0 || busy1) && k < 100) begin
            c0 += int'(busy0); c1 += int'(busy1);
            if (inj) begin   // R7: traffic during busy
                txn_start  = (k == 1);
                txn_addr   = 8'(a ^ 8'h40);
                mode_multi = m;
                data_valid = (k == 2);
                data_byte  = 8'h5A;
                txn_stop   = (k == 3);
            end
            @(negedge clk);
            k++;
        end
        txn_start = 1'b0; data_valid = 1'b0; txn_stop = 1'b0;
        chk(c0 == e0, m ? "R4 R5 open busy length" : "R4 R5 R9 open busy length", c0, e0);
        chk(c1 == e1, "R4 R8 protected busy length", c1, e1);
        if (n > 0) begin
            if (m) begin
                for (int i = 0; i < nb; i++) exp0[(a + i) & 255] = d[i];
            end else begin
                for (int i = 0; i < n; i++) exp0[(a & 8'hF8) | ((a + i) & 7)] = d[i];
            end
            if (!wc) begin
                for (int i = 0; i < n; i++) exp1[(a & 8'hF8) | ((a + i) & 7)] = d[i];
            end
        end
        sweep(m ? "R3 R7 R10 open multibyte contents" : "R2 R7 R9 R10 open page contents",
              wc ? "R8 protected discard" : "R2 R8 protected page contents");
    endtask

    initial begin
        int addrs [9] = '{0, 3, 5, 7, 8'h7A, 8'hFC, 8'hFD, 8'hFE, 8'hFF};
        for (int i = 0; i < 256; i++) begin exp0[i] = 8'hFF; exp1[i] = 8'hFF; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy0 == 1'b0, "R1 reset busy open", busy0, 0);
        chk(busy1 == 1'b0, "R1 reset busy protected", busy1, 0);
        sweep("R1 reset contents open", "R1 reset contents protected");
        for (int ai = 0; ai < 9; ai++)
            for (int n = 0; n < 10; n++)
                for (int m = 0; m < 2; m++)
                    for (int wc = 0; wc < 2; wc++)
                        run_txn(addrs[ai], n, m[0], wc[0], 1'b0);
        run_txn(8'h21, 3, 1'b0, 1'b0, 1'b1);   // R7
        run_txn(8'h86, 4, 1'b1, 1'b0, 1'b1);   // R7 with long cycle
        run_txn(8'h10, 0, 1'b1, 1'b0, 1'b0);   // R5
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 180000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule